// File: doc/BRIEF.md
# Shared-Memory Wait-State Controller

This controller sits between a processor bus and three targets: a memory region that a video fetch engine also reads, a private fast memory, and a slow peripheral window. For each processor access it decides how many wait states to insert. It drives a one-clock completion pulse and a wait indication back to the processor, a grant to the video engine, and a select for the target that is being accessed.

A bus cycle with no waits lasts four clocks. There are two sources of waits, and they add. The first is contention. On the shared region, a free-running slot counter gives the video engine two slots out of every four. An access that starts in a video slot is held until the first processor slot. The second is a per-region memory-timing count, set so that the stretched cycle covers the memory's cycle time. For example, four clocks at 5 MHz is 800 ns, so a 1000 ns memory needs one wait. The peripheral window always adds one more wait on top of its count, whatever the slot phase. The fast region never waits for video.

The state machine has four states. `ST_IDLE` accepts a request and goes to `ST_CONTEND` (shared access in a video slot) or to `ST_ACCESS`. `ST_CONTEND` stays put while the slot is video-owned and moves to `ST_ACCESS` on a processor slot. `ST_ACCESS` counts down and moves to `ST_DONE` when the count is zero. `ST_DONE` drives the completion pulse and returns to `ST_IDLE`.

Top module: `ws_ctrl`

## Requirements
- R1: Address decode. `cpu_addr` below 0x4000 is shared, below 0x8000 is fast, and anything else is peripheral. Only the decoded region's select is high, and only from the first clock after the processor slot is gained up to and including the completion clock. `tgt_we` is high in that window exactly when `cpu_we` was 1 at the strobe.
- R2: An access with no contention and a total wait count of zero completes with `cpu_ready` high in the third clock after the clock in which the strobe is sampled.
- R3: `cfg_waits` bits [2:0] give the shared count, [5:3] the fast count and [8:6] the peripheral count, each 0 to 7. They are captured only while `rst_n` is low. Changes after reset have no effect.
- R4: Slot values 0 and 1 belong to video; 2 and 3 belong to the processor. A shared access whose strobe clock falls in a video slot gets one wait for each consecutive video-owned clock before the first processor slot.
- R5: Contention waits and memory-timing waits add. The memory count starts only after the processor slot is gained, so completion comes 3 + contention + count clocks after the strobe clock.
- R6: A peripheral access gets its region count plus exactly one wait, independent of the slot phase.
- R7: A fast-region access never waits for video slots.
- R8: `cpu_ready` is high for exactly one clock per access. `cpu_wait` is high from the clock after the strobe up to the clock before `cpu_ready` when the total wait count is nonzero, and low otherwise.
- R9: `vid_grant` is high in every video-owned slot unless the shared select is high. `vid_grant` and `sel_shared` are never high together, and the shared select is held through the memory-timing count.
- R10: A strobe that arrives while an access is in progress, up to and including its `cpu_ready` clock, is ignored. A strobe held high is accepted in the clock after `cpu_ready`.
- R11: While `rst_n` is low, `cpu_ready`, `cpu_wait`, all selects and `tgt_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; configuration is captured while low |
| cpu_req | input | 1 | Processor access strobe |
| cpu_addr | input | AW (16) | Processor address |
| cpu_we | input | 1 | 1 = write, 0 = read |
| slot_cnt | input | SLOT_W (2) | Free-running slot counter |
| cfg_waits | input | 3*WW (9) | Per-region wait counts |
| cpu_ready | output | 1 | One-clock completion pulse |
| cpu_wait | output | 1 | Processor is being held with waits |
| vid_grant | output | 1 | Video engine owns the shared memory this clock |
| sel_shared | output | 1 | Shared-region target select |
| sel_fast | output | 1 | Fast-region target select |
| sel_periph | output | 1 | Peripheral target select |
| tgt_we | output | 1 | Write strobe qualifier toward the selected target |

## Verification
The assertions assume that `slot_cnt` advances by one every clock and wraps. This is what makes a contention run at most two clocks and guarantees that a processor slot follows each video pair. The bench drives the counter in exactly that way. The assertions also assume that `cfg_waits` is stable in the clock before `rst_n` rises. The bench changes the configuration only while reset is held, or well after release, and the second case is how R3 is tested. Strobes are placed at gaps that sweep every slot phase, and one strobe is held high across several accesses so that requests land both while the controller is busy and in the completion clock.

// File: rtl/ws_pkg.sv
package ws_pkg;
    typedef enum logic [1:0] {
        RG_SHARED = 2'd0,
        RG_FAST   = 2'd1,
        RG_PERIPH = 2'd2
    } region_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_CONTEND = 2'd1,
        ST_ACCESS  = 2'd2,
        ST_DONE    = 2'd3
    } state_e;

    localparam int NREG = 3;
endpackage

// File: rtl/ws_decode.sv
module ws_decode
    import ws_pkg::*;
#(
    parameter int AW          = 16,
    parameter int FAST_BASE   = 'h4000,
    parameter int PERIPH_BASE = 'h8000
) (
    input  logic [AW-1:0] addr,
    output region_e       region
);
    localparam logic [AW-1:0] FB = AW'(FAST_BASE);
    localparam logic [AW-1:0] PB = AW'(PERIPH_BASE);

    always_comb begin
        if (addr < FB)
            region = RG_SHARED;
        else if (addr < PB)
            region = RG_FAST;
        else
            region = RG_PERIPH;
    end
endmodule

// File: rtl/ws_cfg.sv
module ws_cfg
    import ws_pkg::*;
#(
    parameter int WW = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NREG*WW-1:0]        cfg_in,
    output logic [NREG-1:0][WW-1:0]   waits
);
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n)
                waits[g] <= cfg_in[g*WW +: WW];
        end
    end

    // R3
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(waits));
endmodule

// File: rtl/ws_slot.sv
module ws_slot #(
    parameter int SLOT_W    = 2,
    parameter int VID_SLOTS = 2
) (
    input  logic [SLOT_W-1:0] slot_cnt,
    input  logic              shared_held,
    output logic              vid_slot,
    output logic              vid_grant
);
    localparam logic [SLOT_W-1:0] VID_LIM = SLOT_W'(VID_SLOTS);

    always_comb begin
        vid_slot  = (slot_cnt < VID_LIM);
        vid_grant = vid_slot && !shared_held;
    end
endmodule

// File: rtl/ws_fsm.sv
module ws_fsm
    import ws_pkg::*;
#(
    parameter int WW = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req,
    input  logic                    we,
    input  region_e                 region,
    input  logic                    vid_slot,
    input  logic [NREG-1:0][WW-1:0] waits,
    output logic                    cpu_ready,
    output logic                    cpu_wait,
    output logic                    tgt_we,
    output logic [NREG-1:0]         sel
);
    localparam int CW = $clog2((1 << WW) + 2);

    state_e          state_q, state_d;
    region_e         reg_q, reg_d;
    logic [CW-1:0]   cnt_q, cnt_d;
    logic            need_q, need_d;
    logic            we_q, we_d;
    logic            contend_now;

    function automatic logic [CW-1:0] mem_waits(region_e r);
        logic [CW-1:0] extra;
        extra = (r == RG_PERIPH) ? CW'(1) : CW'(0);
        return CW'(waits[r]) + extra;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            reg_q   <= RG_SHARED;
            cnt_q   <= '0;
            need_q  <= 1'b0;
            we_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            reg_q   <= reg_d;
            cnt_q   <= cnt_d;
            need_q  <= need_d;
            we_q    <= we_d;
        end
    end

    always_comb begin
        state_d     = state_q;
        reg_d       = reg_q;
        cnt_d       = cnt_q;
        need_d      = need_q;
        we_d        = we_q;
        contend_now = (region == RG_SHARED) && vid_slot;
        unique case (state_q)
            ST_IDLE: begin
                if (req) begin
                    reg_d  = region;
                    we_d   = we;
                    need_d = contend_now || (mem_waits(region) != '0);
                    if (contend_now) begin
                        state_d = ST_CONTEND;
                    end else begin
                        state_d = ST_ACCESS;
                        cnt_d   = CW'(1) + mem_waits(region);
                    end
                end
            end
            ST_CONTEND: begin
                if (!vid_slot) begin
                    state_d = ST_ACCESS;
                    cnt_d   = CW'(1) + mem_waits(reg_q);
                end
            end
            ST_ACCESS: begin
                if (cnt_q == '0)
                    state_d = ST_DONE;
                else
                    cnt_d = cnt_q - CW'(1);
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    always_comb begin
        cpu_ready = (state_q == ST_DONE);
        cpu_wait  = need_q && ((state_q == ST_CONTEND) || (state_q == ST_ACCESS));
        sel       = '0;
        tgt_we    = 1'b0;
        if ((state_q == ST_ACCESS) || (state_q == ST_DONE)) begin
            sel[reg_q] = 1'b1;
            tgt_we     = we_q;
        end
    end

    // R8
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);

    // R8
    ready_nowait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> !cpu_wait);

    // R10
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> $stable(reg_q) && $stable(we_q));

    // R7
    fast_no_contend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CONTEND) |-> (reg_q == RG_SHARED));

    // R4
    contend_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CONTEND && !vid_slot) |=> (state_q == ST_ACCESS));

    // R6
    periph_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACCESS && reg_q == RG_PERIPH) |-> cpu_wait);
endmodule

// File: rtl/ws_ctrl.sv
module ws_ctrl
    import ws_pkg::*;
#(
    parameter int AW          = 16,
    parameter int WW          = 3,
    parameter int SLOT_W      = 2,
    parameter int VID_SLOTS   = 2,
    parameter int FAST_BASE   = 'h4000,
    parameter int PERIPH_BASE = 'h8000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpu_req,
    input  logic [AW-1:0]      cpu_addr,
    input  logic               cpu_we,
    input  logic [SLOT_W-1:0]  slot_cnt,
    input  logic [3*WW-1:0]    cfg_waits,
    output logic               cpu_ready,
    output logic               cpu_wait,
    output logic               vid_grant,
    output logic               sel_shared,
    output logic               sel_fast,
    output logic               sel_periph,
    output logic               tgt_we
);
    region_e                 region;
    logic [NREG-1:0][WW-1:0] waits;
    logic [NREG-1:0]         sel;
    logic                    vid_slot;

    ws_decode #(.AW(AW), .FAST_BASE(FAST_BASE), .PERIPH_BASE(PERIPH_BASE)) u_dec (
        .addr   (cpu_addr),
        .region (region)
    );

    ws_cfg #(.WW(WW)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .cfg_in (cfg_waits),
        .waits  (waits)
    );

    ws_slot #(.SLOT_W(SLOT_W), .VID_SLOTS(VID_SLOTS)) u_slot (
        .slot_cnt    (slot_cnt),
        .shared_held (sel[0]),
        .vid_slot    (vid_slot),
        .vid_grant   (vid_grant)
    );

    ws_fsm #(.WW(WW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (cpu_req),
        .we        (cpu_we),
        .region    (region),
        .vid_slot  (vid_slot),
        .waits     (waits),
        .cpu_ready (cpu_ready),
        .cpu_wait  (cpu_wait),
        .tgt_we    (tgt_we),
        .sel       (sel)
    );

    assign sel_shared = sel[0];
    assign sel_fast   = sel[1];
    assign sel_periph = sel[2];

    // R9
    vid_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(vid_grant && sel_shared));

    // R1
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_periph, sel_fast, sel_shared}));
endmodule

// File: tb/tb_ws_ctrl.sv
module tb_ws_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_we = 1'b0;
    logic [1:0]  slot_cnt = '0;
    logic [8:0]  cfg_waits = '0;
    logic        cpu_ready, cpu_wait, vid_grant, sel_shared, sel_fast, sel_periph, tgt_we;

    int tests = 0;
    int fails = 0;
    int cyc = 0;

    // reference model record of the current access
    int mcfg [3];
    int acc_c = -100, k_m = 0, mw_m = 0, rdy_c = -100, reg_m = 0;
    bit we_m = 0, need_m = 0;

    always #4 clk = ~clk;

    ws_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
        .cpu_we(cpu_we), .slot_cnt(slot_cnt), .cfg_waits(cfg_waits),
        .cpu_ready(cpu_ready), .cpu_wait(cpu_wait), .vid_grant(vid_grant),
        .sel_shared(sel_shared), .sel_fast(sel_fast), .sel_periph(sel_periph),
        .tgt_we(tgt_we)
    );

    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) slot_cnt <= slot_cnt + 2'd1;

    function automatic int region_of(logic [15:0] a);
        if (a < 16'h4000) return 0;
        if (a < 16'h8000) return 1;
        return 2;
    endfunction

    // per-clock comparison against the behavioural model
    always @(negedge clk) begin
        #1;
        if (!rst_n) begin
            // R11 reset state; R3 capture of the configuration
            tests++;
            if (cpu_ready || cpu_wait || sel_shared || sel_fast || sel_periph || tgt_we
                || (vid_grant !== (slot_cnt < 2))) begin
                fails++;
                $display("FAIL R11 cycle %0d actual rdy=%0b wt=%0b sel=%0b%0b%0b we=%0b vg=%0b expected all 0 vg=%0b",
                         cyc, cpu_ready, cpu_wait, sel_periph, sel_fast, sel_shared, tgt_we,
                         vid_grant, slot_cnt < 2);
            end
            mcfg[0] = int'(cfg_waits[2:0]);
            mcfg[1] = int'(cfg_waits[5:3]);
            mcfg[2] = int'(cfg_waits[8:6]);
            rdy_c = -100;
            acc_c = -100;
        end else begin
            int t;
            bit e_rdy, e_wt, e_vg, e_we;
            bit [2:0] e_sel, a_sel;
            string tag;
            t = cyc;
            e_rdy = (t == rdy_c);
            e_wt  = need_m && (t >= acc_c + 1) && (t <= rdy_c - 1);
            e_sel = '0;
            if ((t >= acc_c + k_m + 1) && (t <= rdy_c)) e_sel[reg_m] = 1'b1;
            e_we  = we_m && (e_sel != 0);
            e_vg  = (slot_cnt < 2) && !e_sel[0];
            a_sel = {sel_periph, sel_fast, sel_shared};
            tests++;
            if (cpu_ready !== e_rdy || cpu_wait !== e_wt || a_sel !== e_sel
                || tgt_we !== e_we || vid_grant !== e_vg) begin
                fails++;
                tag = "";
                if (cpu_ready !== e_rdy || cpu_wait !== e_wt)
                    tag = {tag, "R2 R4 R5 R6 R7 R8 R10 "};
                if (a_sel !== e_sel || tgt_we !== e_we) tag = {tag, "R1 "};
                if (vid_grant !== e_vg) tag = {tag, "R9 "};
                $display("FAIL %scycle %0d actual rdy=%0b wt=%0b sel=%03b we=%0b vg=%0b expected rdy=%0b wt=%0b sel=%03b we=%0b vg=%0b",
                         tag, t, cpu_ready, cpu_wait, a_sel, tgt_we, vid_grant,
                         e_rdy, e_wt, e_sel, e_we, e_vg);
            end
            // R10: only a strobe after the previous ready clock starts a new access
            if (cpu_req && t > rdy_c) begin
                acc_c = t;
                reg_m = region_of(cpu_addr);
                we_m  = cpu_we;
                k_m   = 0;
                if (reg_m == 0)
                    while (((int'(slot_cnt) + k_m) % 4) < 2) k_m++;
                mw_m   = mcfg[reg_m] + ((reg_m == 2) ? 1 : 0);
                rdy_c  = t + 3 + k_m + mw_m;
                need_m = (k_m + mw_m) > 0;
            end
        end
    end

    task automatic issue(input logic [15:0] a, input logic w, input int gap);
        cpu_req  = 1'b1;
        cpu_addr = a;
        cpu_we   = w;
        @(negedge clk);
        cpu_req  = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    initial begin
        // first configuration: shared 1, fast 0, peripheral 2
        cfg_waits = {3'd2, 3'd0, 3'd1};
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R3: later changes must not alter the captured counts
        cfg_waits = {3'd7, 3'd7, 3'd7};
        @(negedge clk);
        // R4 R5: shared accesses swept across every slot phase
        for (int j = 0; j < 8; j++) issue(16'h0100, j[0], 16 + j);
        // R7 R2: fast region, zero waits, any phase
        for (int j = 0; j < 4; j++) issue(16'h5000, j[0], 16 + j);
        // R6: peripheral at every phase
        for (int j = 0; j < 4; j++) issue(16'h9000, ~j[0], 16 + j);
        // R10: held strobe lands while busy and in the ready clock
        cpu_req = 1'b1; cpu_addr = 16'h0200; cpu_we = 1'b1;
        repeat (30) @(negedge clk);
        cpu_addr = 16'h9100;
        repeat (20) @(negedge clk);
        cpu_req = 1'b0;
        repeat (20) @(negedge clk);
        // second configuration: shared 0, fast 3, peripheral 0
        rst_n = 1'b0;
        cfg_waits = {3'd0, 3'd3, 3'd0};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: shared at processor slot with no memory waits
        for (int j = 0; j < 4; j++) issue(16'h3FFF, j[0], 16 + j);
        for (int j = 0; j < 2; j++) issue(16'h4000, 1'b1, 16 + j);
        for (int j = 0; j < 2; j++) issue(16'h8000, 1'b0, 16 + j);
        issue(16'h7FFF, 1'b0, 20);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL R10 watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule